// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a synthesizable model of a small byte-addressable non-volatile memory that sits behind a two-wire serial bus (I2C style). It samples the clock and data lines with a short synchronizer. It finds the bus framing events and answers to a 7-bit device address. Four of the address bits are fixed, and three come from strap inputs, so eight copies can share one bus. The data line is open-drain and is modelled as an output enable: when the enable is high, the pin is pulled low.

A write transaction sends the device address, then a two-byte word address, then data bytes. The data bytes are collected in a page buffer. They reach the storage array only when the master ends the transaction with a STOP. The array is then busy for a self-timed window that is set by a parameter in clock cycles. During that window the device stays silent on its own address, so the master can poll for completion. A read either continues from the internal address counter or sets that counter first with a dummy write and a repeated START. The master can keep reading sequentially by acknowledging each byte.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` low), the device is not busy, the address counter is 0 and every storage byte reads as 0x00.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point restarts reception of the address byte and leaves the address counter unchanged unless both word-address bytes were taken. The device changes `sda_oe` only while SCL is low.
- R3: The address byte is sent MSB first. Bits 7..1 must equal 1010 followed by `strap_i[2]`, `strap_i[1]` and `strap_i[0]`, and bit 0 is 1 for a read. On a match the device pulls SDA low in the ninth clock. On a mismatch it does not, and it leaves SDA released until the next START.
- R4: After a write-flagged address the device takes a high and then a low word-address byte, then data bytes, and acknowledges each one. Word-address bits at or above `MEM_AW` are ignored.
- R5: Data bytes are held in the page buffer, and the array is unchanged until a STOP. A STOP after at least one buffered byte programs those bytes. A repeated START does not program them.
- R6: Within a write, the low 5 address bits step and wrap inside the 32-byte page. A byte sent to a page slot that was already used replaces the earlier one, so the last byte sent wins.
- R7: After a programming STOP the device does not acknowledge its address for at least `WRITE_CYCLES` clocks. After that it acknowledges again.
- R8: A random read (dummy write of the word address, repeated START, read-flagged address) returns the byte at that address MSB first, one bit per SCL clock.
- R9: A current-address read returns the byte at the counter. After a read the counter is one past the last byte sent. After a page write it is one past the last slot written, wrapped within the page.
- R10: When the master acknowledges, the next byte follows at the next address. The counter rolls over from 2^`MEM_AW`-1 to 0.
- R11: A master NACK ends the read. SDA stays released through any further clocks until the next START or STOP, and a STOP always releases SDA.
- R12: Data bytes received while `wp_i` is high are acknowledged but not stored. If no byte was stored, a STOP starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| sda_oe | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Low three device-address bits |
| wp_i | input | 1 | High blocks storage of incoming data bytes |

## Verification
The synchronizer and edge detector add about four clocks between a pin edge and the block's reaction. The bench therefore holds each SCL phase for eight or more clocks, and it samples the acknowledge and read bits in the middle of the SCL high phase, well after `sda_oe` has settled. A programming cycle ends `WRITE_CYCLES` clocks after the STOP, plus the poll latency. The bench measures the clock count from STOP to the first acknowledged poll and requires it to be no shorter than that window. It also requires the very first poll to be refused. Read data is due in the high phase that follows each SCL fall. The bench compares every byte against a model of the array and the address counter, and that model is kept only from the requirements.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/nvm_bus_sampler.sv
module nvm_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_hi,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sync;
  logic [LAST:0] sda_sync;
  logic          scl_d;
  logic          sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[LAST-1:0], scl_i};
      sda_sync <= {sda_sync[LAST-1:0], sda_i};
      scl_d    <= scl_sync[LAST];
      sda_d    <= sda_sync[LAST];
    end
  end

  assign scl_hi   = scl_sync[LAST];
  assign sda_hi   = sda_sync[LAST];
  assign start_ev = scl_hi & scl_d & sda_d & ~sda_hi;
  assign stop_ev  = scl_hi & scl_d & ~sda_d & sda_hi;
  assign rise_ev  = scl_hi & ~scl_d;
  assign fall_ev  = ~scl_hi & scl_d;
endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int SLOTS = 2 ** AW;

  logic [DW-1:0]    slot [SLOTS];
  logic [SLOTS-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) slot[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[waddr] <= 1'b1;
  end

  assign rdata  = slot[raddr];
  assign rvalid = vld[raddr];
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave #(
  parameter int MEM_AW       = 8,
  parameter int PAGE_AW      = 5,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import nvm_pkg::*;

  localparam int BUSY_LEN = (WRITE_CYCLES > (2 ** PAGE_AW)) ? WRITE_CYCLES : (2 ** PAGE_AW) + 1;
  localparam int CW       = $clog2(BUSY_LEN + 1);
  localparam logic [MEM_AW-1:0]  PTR_ONE   = 1;
  localparam logic [PAGE_AW-1:0] PG_ONE    = 1;
  localparam logic [PAGE_AW-1:0] PAGE_LAST = '1;
  localparam logic [CW-1:0]      BC_ONE    = 1;
  localparam logic [3:0]         BIT_ONE   = 1;

  logic scl_hi, sda_hi, start_ev, stop_ev, rise_ev, fall_ev;

  nvm_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_hi(sda_hi), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  phase_e            phase;
  logic [7:0]        shreg, tx, ahi;
  logic [3:0]        bcnt;
  logic              in_ack, mack, any_buf;
  logic [MEM_AW-1:0] ptr;
  logic              buf_clr, buf_we;
  logic [PAGE_AW-1:0] buf_wa;
  logic [7:0]        buf_wd, buf_rd, rdata;
  logic              buf_rv;
  logic [CW-1:0]     busy_cnt;
  logic              busy, com_act, mem_we;
  logic [PAGE_AW-1:0] com_idx;
  logic [MEM_AW-1:0] mem_wa;
  logic [15:0]       word_addr;
  logic              unused_hi;

  assign word_addr = {ahi, shreg};
  assign unused_hi = ^word_addr[15:MEM_AW];
  assign busy      = (busy_cnt != '0);
  assign mem_we    = com_act & buf_rv;
  assign mem_wa    = {ptr[MEM_AW-1:PAGE_AW], com_idx};

  nvm_page_buf #(.AW(PAGE_AW), .DW(8)) u_page (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .waddr(buf_wa),
    .wdata(buf_wd), .raddr(com_idx), .rdata(buf_rd), .rvalid(buf_rv)
  );

  nvm_store #(.AW(MEM_AW), .DW(8)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(buf_rd),
    .raddr(ptr), .rdata(rdata)
  );

  // Bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bcnt    <= '0;
      in_ack  <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      shreg   <= '0;
      tx      <= '0;
      ahi     <= '0;
      ptr     <= '0;
      any_buf <= 1'b0;
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      buf_wa  <= '0;
      buf_wd  <= '0;
    end else begin
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      if (start_ev) begin
        phase  <= PH_DEV;
        bcnt   <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        phase   <= PH_IDLE;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        any_buf <= 1'b0;
      end else if (phase == PH_RD) begin
        if (rise_ev) begin
          if (in_ack) mack <= ~sda_hi;
          else        bcnt <= bcnt + BIT_ONE;
        end else if (fall_ev) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            if (mack) begin
              tx     <= rdata;
              sda_oe <= ~rdata[7];
              bcnt   <= '0;
              ptr    <= ptr + PTR_ONE;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_IDLE;
            end
          end else if (bcnt == 4'd8) begin
            sda_oe <= 1'b0;
            in_ack <= 1'b1;
          end else begin
            sda_oe <= ~tx[6];
            tx     <= {tx[6:0], 1'b0};
          end
        end
      end else if (phase != PH_IDLE) begin
        if (rise_ev && !in_ack && bcnt != 4'd8) begin
          shreg <= {shreg[6:0], sda_hi};
          bcnt  <= bcnt + BIT_ONE;
        end else if (fall_ev && in_ack) begin
          in_ack <= 1'b0;
          sda_oe <= 1'b0;
          bcnt   <= '0;
        end else if (fall_ev && bcnt == 4'd8) begin
          case (phase)
            PH_DEV: begin
              if (shreg[7:1] == {DEV_PREFIX, strap_i} && !busy) begin
                sda_oe <= 1'b1;
                in_ack <= 1'b1;
                mack   <= 1'b1;
                phase  <= shreg[0] ? PH_RD : PH_AHI;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_AHI: begin
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
              ahi    <= shreg;
              phase  <= PH_ALO;
            end
            PH_ALO: begin
              sda_oe  <= 1'b1;
              in_ack  <= 1'b1;
              ptr     <= word_addr[MEM_AW-1:0];
              buf_clr <= 1'b1;
              any_buf <= 1'b0;
              phase   <= PH_WR;
            end
            PH_WR: begin
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
              if (!wp_i) begin
                buf_we  <= 1'b1;
                buf_wa  <= ptr[PAGE_AW-1:0];
                buf_wd  <= shreg;
                any_buf <= 1'b1;
              end
              ptr <= {ptr[MEM_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + PG_ONE};
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // Self-timed programming window and page commit sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      com_act  <= 1'b0;
      com_idx  <= '0;
    end else if (stop_ev && phase == PH_WR && any_buf) begin
      busy_cnt <= CW'(BUSY_LEN);
      com_act  <= 1'b1;
      com_idx  <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - BC_ONE;
      if (com_act) begin
        com_idx <= com_idx + PG_ONE;
        if (com_idx == PAGE_LAST) com_act <= 1'b0;
      end
    end
  end

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R5
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_ev));

  // R5
  store_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R2
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_hi);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);
endmodule

// File: tb/test_serial_nvm_slave.sv
`timescale 1ns/1ps
module test_serial_nvm_slave;
  localparam int MEM_AW = 8;
  localparam int WC     = 600;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV   = {4'b1010, STRAP};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  serial_nvm_slave #(.MEM_AW(MEM_AW), .PAGE_AW(5), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) i_serial_nvm_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(STRAP), .wp_i(wp)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit drove_seen = 1'b0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  logic [7:0] wbuf [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mon_en && sda_oe) drove_seen <= 1'b1;
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(8);
    scl_m = 1'b1; hold(8);
    sda_m = 1'b0; hold(8);
    scl_m = 1'b0; hold(8);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(8);
    scl_m = 1'b1; hold(8);
    sda_m = 1'b1; hold(8);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; hold(8);
    scl_m = 1'b1; hold(8);
    scl_m = 1'b0; hold(8);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; hold(8);
    scl_m = 1'b1; hold(4);
    b = sda_line; hold(4);
    scl_m = 1'b0; hold(8);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic set_addr(input logic [15:0] a, input string tag);
    bit ack;
    send_byte({DEV, 1'b0}, ack); chk(ack, tag, ack, 1);
    send_byte(a[15:8], ack);     chk(ack, tag, ack, 1);
    send_byte(a[7:0], ack);      chk(ack, tag, ack, 1);
  endtask

  task automatic page_write(input logic [15:0] a, input int n, input string tag);
    bit ack;
    logic [4:0] lo;
    bus_start();
    set_addr(a, tag);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack, tag, ack, 1);
    end
    bus_stop();
    for (int i = 0; i < n; i++) begin
      lo = a[4:0] + 5'(i);
      if (!wp) ref_mem[{a[7:5], lo}] = wbuf[i];
    end
    lo = a[4:0] + 5'(n);
    ref_ptr = {a[7:5], lo};
  endtask

  task automatic wait_ready(input bit expect_busy, input string tag);
    bit ack;
    int t0;
    int el;
    t0 = cyc;
    el = 0;
    ack = 1'b0;
    for (int k = 0; k < 12 && !ack; k++) begin
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      el = cyc - t0;
      bus_stop();
      if (k == 0) chk(ack == !expect_busy, tag, ack, !expect_busy);
    end
    chk(ack, tag, ack, 1);
    if (expect_busy) chk(el >= WC, tag, el, WC);
  endtask

  task automatic read_tail(input int n, input logic [7:0] first, input string tag);
    logic [7:0] v;
    bit b;
    int low_seen;
    for (int i = 0; i < n; i++) begin
      recv_byte(v, i != n - 1);
      chk(v == ref_mem[8'(first + 8'(i))], tag, v, ref_mem[8'(first + 8'(i))]);
    end
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);
    low_seen = 0;
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      if (!b) low_seen++;
    end
    chk(low_seen == 0, "R11", low_seen, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);
    ref_ptr = first + 8'(n);
  endtask

  task automatic random_read(input logic [15:0] a, input int n, input string tag);
    bit ack;
    bus_start();
    set_addr(a, tag);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R8", ack, 1);
    read_tail(n, a[7:0], tag);
  endtask

  task automatic current_read(input int n, input string tag);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, tag, ack, 1);
    read_tail(n, ref_ptr, tag);
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    bit ack;
    logic [7:0] v;
    logic [15:0] ra;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    ref_ptr = 8'h00;
    hold(10);
    rst = 1'b0;
    hold(4);

    // R1: reset state, counter at 0, zero contents
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    current_read(1, "R1");

    // R3: wrong strap bits and wrong prefix are ignored
    mon_en = 1'b1;
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ack);
    chk(!ack, "R3", ack, 0);
    send_byte(8'h00, ack);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, ack);
    chk(!ack, "R3", ack, 0);
    send_byte(8'hFF, ack);
    bus_stop();
    mon_en = 1'b0;
    chk(!drove_seen, "R3", drove_seen, 0);

    // R4: high word-address bits dropped
    wbuf[0] = 8'hC3;
    page_write(16'h3A05, 1, "R4");
    wait_ready(1'b1, "R7");
    random_read(16'h0005, 1, "R4");

    // R6: 40 bytes into one page wrap and overwrite
    for (int i = 0; i < 40; i++) wbuf[i] = 8'($urandom);
    page_write(16'h0025, 40, "R6");
    wait_ready(1'b1, "R7");
    random_read(16'h0020, 32, "R6");

    // R9: counter after a page write
    for (int i = 0; i < 3; i++) wbuf[i] = 8'h70 + 8'(i);
    page_write(16'h005E, 3, "R9");
    wait_ready(1'b1, "R7");
    current_read(1, "R9");

    // R5: repeated START does not program
    bus_start();
    set_addr(16'h0090, "R5");
    send_byte(8'h5A, ack);
    chk(ack, "R5", ack, 1);
    bus_start();
    set_addr(16'h0090, "R5");
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R5", ack, 1);
    recv_byte(v, 1'b0);
    chk(v == ref_mem[8'h90], "R5", v, ref_mem[8'h90]);
    bus_stop();
    ref_ptr = 8'h91;
    wait_ready(1'b0, "R5");
    random_read(16'h0090, 1, "R5");

    // R12: write protect
    wp = 1'b1;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hE0 + 8'(i);
    page_write(16'h00A0, 4, "R12");
    wp = 1'b0;
    wait_ready(1'b0, "R12");
    random_read(16'h00A0, 4, "R12");

    // R10: sequential read rolls over the top of the array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    page_write(16'h00FE, 2, "R10");
    wait_ready(1'b1, "R7");
    wbuf[0] = 8'h33; wbuf[1] = 8'h44;
    page_write(16'h0000, 2, "R10");
    wait_ready(1'b1, "R7");
    random_read(16'h00FE, 4, "R10");

    // R2: START in the middle of the word address restarts address reception
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R2", ack, 1);
    send_byte(8'h00, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R2", ack, 1);
    read_tail(1, ref_ptr, "R2");

    // R8: constrained random writes then reads
    for (int t = 0; t < 8; t++) begin
      ra = 16'($urandom);
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      page_write(ra, n, "R8");
      wait_ready(1'b1, "R7");
      random_read(ra, n, "R8");
      ra = 16'($urandom);
      random_read(ra, 1 + int'($urandom % 3), "R8");
      current_read(1, "R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule